// File: doc/BRIEF.md
# Bidirectional Four-Cell Shift Register

This block is a four-cell register whose next contents are picked each clock by a two-bit mode. It can keep its value, move every bit one cell toward the right end, move every bit one cell toward the left end, or take a new four-bit word in a single clock. Serial data can enter at either end, and both end cells are brought out as serial taps. The full contents are also visible as a parallel word.

Each cell is a flip-flop fed by a four-way selector. The choices are the cell's own value, its left neighbour, its right neighbour and its bit of the parallel input. At the two ends, the missing neighbour is replaced by the serial input on that side. A clear input sets every cell to zero on the next rising edge and overrides the mode. Everything changes on one rising clock edge.

Top module: `bidir_shift_reg4`

## Requirements
- R1: The register holds CELLS bits (default 4) and shows them all on `word_q`. Bit `word_q[CELLS-1]` is the leftmost cell and `word_q[0]` is the rightmost.
- R2: When `clr` is 1 at a rising edge, `word_q` becomes all zeros after that edge, for any mode value.
- R3: With `clr` low, mode {`sel_hi`,`sel_lo`} = 00 leaves `word_q` unchanged across the edge.
- R4: With `clr` low, mode 01 shifts right: `word_q` becomes {`fill_left`, old `word_q[CELLS-1:1]`}.
- R5: With `clr` low, mode 10 shifts left: `word_q` becomes {old `word_q[CELLS-2:0]`, `fill_right`}.
- R6: With `clr` low, mode 11 copies `word_d` into `word_q` in one clock.
- R7: `tap_left` always equals the leftmost cell and `tap_right` always equals the rightmost cell. Both come straight from the cells with no extra delay.
- R8: Before the first clock edge, the contents read as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, overrides the mode |
| sel_hi | input | 1 | High-order mode select bit |
| sel_lo | input | 1 | Low-order mode select bit |
| fill_left | input | 1 | Serial bit entering the leftmost cell on a right shift |
| fill_right | input | 1 | Serial bit entering the rightmost cell on a left shift |
| word_d | input | CELLS | Parallel load word |
| word_q | output | CELLS | Current contents |
| tap_left | output | 1 | Leftmost cell |
| tap_right | output | 1 | Rightmost cell |

## Verification
The bench builds the register with the default of four cells. At that width, a few hundred random cycles reach every mode with every pattern of the two serial inputs. They also reach every contents value, including shifting a bit all the way out of one end while a new bit enters at the other. Directed steps assert clear under each of the four modes and check power-up at zero.

// File: rtl/bidir_shift_reg4.sv
module bidir_shift_reg4 #(
  parameter int CELLS = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             sel_hi,
  input  logic             sel_lo,
  input  logic             fill_left,
  input  logic             fill_right,
  input  logic [CELLS-1:0] word_d,
  output logic [CELLS-1:0] word_q,
  output logic             tap_left,
  output logic             tap_right
);
  localparam logic [1:0] M_HOLD  = 2'b00;
  localparam logic [1:0] M_RIGHT = 2'b01;
  localparam logic [1:0] M_LEFT  = 2'b10;
  localparam logic [1:0] M_LOAD  = 2'b11;

  logic [1:0]       mode;
  logic [CELLS-1:0] cells = '0;
  logic [CELLS+1:0] ring;
  logic [CELLS-1:0] nxt;

  assign mode = {sel_hi, sel_lo};
  assign ring = {fill_left, cells, fill_right};

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    always_comb begin
      unique case (mode)
        M_HOLD:  nxt[i] = cells[i];
        M_RIGHT: nxt[i] = ring[i+2];
        M_LEFT:  nxt[i] = ring[i];
        default: nxt[i] = word_d[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (clr) cells <= '0;
    else     cells <= nxt;
  end

  assign word_q    = cells;
  assign tap_left  = cells[CELLS-1];
  assign tap_right = cells[0];

  AST_CLEAR_ZERO: assert property (@(posedge clk) clr |=> (word_q == '0)); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (clr)
    (mode == M_HOLD) |=> $stable(word_q)); // R3
  AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (clr)
    (mode == M_RIGHT) |=> (word_q == {$past(fill_left), $past(word_q[CELLS-1:1])})); // R4
  AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (clr)
    (mode == M_LEFT) |=> (word_q == {$past(word_q[CELLS-2:0]), $past(fill_right)})); // R5
  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (clr)
    (mode == M_LOAD) |=> (word_q == $past(word_d))); // R6
endmodule

// File: tb/bidir_shift_reg4_tb.sv
module bidir_shift_reg4_tb;
  localparam int CELLS = 4;

  logic clk = 1'b0;
  logic clr = 1'b0, sel_hi = 1'b0, sel_lo = 1'b0, fill_left = 1'b0, fill_right = 1'b0;
  logic [CELLS-1:0] word_d = '0;
  logic [CELLS-1:0] word_q;
  logic tap_left, tap_right;
  logic [CELLS-1:0] model = '0;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bidir_shift_reg4 #(.CELLS(CELLS)) u_dut (
    .clk(clk), .clr(clr), .sel_hi(sel_hi), .sel_lo(sel_lo),
    .fill_left(fill_left), .fill_right(fill_right), .word_d(word_d),
    .word_q(word_q), .tap_left(tap_left), .tap_right(tap_right));

  function automatic logic [CELLS-1:0] ref_next(logic [CELLS-1:0] cur, logic c,
      logic [1:0] m, logic fl, logic fr, logic [CELLS-1:0] d);
    if (c) return '0;
    case (m)
      2'b00: return cur;
      2'b01: return {fl, cur[CELLS-1:1]};
      2'b10: return {cur[CELLS-2:0], fr};
      default: return d;
    endcase
  endfunction

  function automatic string req_of(logic c, logic [1:0] m);
    if (c) return "R2";
    case (m)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6 R1";
    endcase
  endfunction

  task automatic check(string req, logic [CELLS-1:0] act, logic [CELLS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(logic c, logic [1:0] m, logic fl, logic fr, logic [CELLS-1:0] d);
    clr = c; {sel_hi, sel_lo} = m; fill_left = fl; fill_right = fr; word_d = d;
    model = ref_next(model, c, m, fl, fr, d);
    @(negedge clk);
    check(req_of(c, m), word_q, model);
    check("R7 left", {3'b0, tap_left}, {3'b0, model[CELLS-1]});
    check("R7 right", {3'b0, tap_right}, {3'b0, model[0]});
  endtask

  initial begin
    int seed;
    seed = 32'h1f3a;
    void'($urandom(seed));
    #1;
    check("R8", word_q, '0);
    @(negedge clk);
    step(1'b1, 2'b00, 1'b0, 1'b0, '0);
    step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1001);
    step(1'b0, 2'b01, 1'b1, 1'b0, '0);
    step(1'b0, 2'b01, 1'b0, 1'b0, '0);
    step(1'b0, 2'b10, 1'b0, 1'b1, '0);
    step(1'b0, 2'b00, 1'b1, 1'b1, 4'b0110);
    for (int m = 0; m < 4; m++) begin
      step(1'b0, 2'b11, 1'b1, 1'b1, 4'b1111);
      step(1'b1, m[1:0], 1'b1, 1'b1, 4'b1111);
    end
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[4:0] == 5'd0, r[6:5], r[7], r[8], r[12:9]);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule